// File: doc/BRIEF.md
# Power-Control Register Access Engine

This engine carries out register access requests that reach a service processor through a mailbox. One request carries a command code, a 4-bit sub-id, a byte count and a 16-byte write buffer. The engine checks the request and reads the list of 16-bit register addresses packed in the buffer. It then reads, writes or masked-updates an attached byte-wide register file, one access per clock. Read results are collected into a 16-byte read buffer. When the work is finished, the engine pulses `done` and reports an error flag and an error code.

Requests enter through a valid/ready handshake. `cmd_ready` is high only while the engine is idle. A request is taken on the rising edge where `cmd_valid` and `cmd_ready` are both high. From that edge until the cycle after `done`, `cmd_ready` stays low, so a waiting requester holds its fields and `cmd_valid` steady. The register file port has no back-pressure. A write commits on the clock edge that ends the access cycle. Read data (`rf_rdata`) must be valid in the same cycle as `rf_addr`.

Top module: `pwr_reg_engine`

## Requirements
- R1: `cmd_ready` is high exactly when the engine is idle. It drops in the cycle after a request is accepted and returns in the cycle after `done`. No register access occurs while `cmd_ready` is high.
- R2: A request whose command code is not 0xFF performs no register access and finishes with `err`=1 and `err_code`=1.
- R3: A request with code 0xFF and a sub-id other than 0 (write), 1 (read) or 2 (masked update) performs no register access and finishes with `err`=1 and `err_code`=2.
- R4: For a size that breaks the sub-id rule, the request performs no register access and finishes with `err`=1 and `err_code`=3. The rules are: read needs an even size and count = size/2; write needs a multiple of 3 and count = size/3; masked update needs exactly 4. The count must lie between 1 and 5. A rejected request pulses `done` in cycle 1 after the accept edge.
- R5: Item i's address is write-buffer byte 2i (low byte) and byte 2i+1 (high byte). Items are accessed in list order, one per cycle, in cycles 1..n after the accept edge.
- R6: For a read, byte i of `rbuf` holds the register value read for item i. All bytes of `rbuf` from n upward are zero.
- R7: For a write, item i writes write-buffer byte 2n+i to its address.
- R8: A masked update reads its address in cycle 1. In cycle 2 it writes (old & ~mask) | (value & mask), where value is buffer byte 2 and mask is buffer byte 3.
- R9: `done` is a one-cycle pulse. It comes in cycle n+1 for reads and writes and in cycle 3 for a masked update. On success, `err`=0 and `err_code`=0.
- R10: `rbuf`, `err` and `err_code` are cleared or replaced on each accept and then hold until the next accept. After a write or a masked update, `rbuf` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Engine idle, request will be taken |
| cmd_code | input | 8 | Command code (0xFF handled) |
| cmd_sub | input | 4 | Sub-id: 0 write, 1 read, 2 masked update |
| cmd_size | input | 8 | Payload size in bytes |
| cmd_wbuf | input | 128 | Write buffer, byte k at bits 8k+7:8k |
| rf_en | output | 1 | Register file access this cycle |
| rf_we | output | 1 | Access is a write |
| rf_addr | output | 16 | Register address |
| rf_wdata | output | 8 | Write data |
| rf_rdata | input | 8 | Read data, same cycle as address |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected |
| err_code | output | 8 | 0 ok, 1 bad code, 2 bad sub-id, 3 bad size |
| rbuf | output | 128 | Read buffer, byte i at bits 8i+7:8i |

## Verification
Counting the accept edge as cycle 0, each access must appear in cycles 1..n. A masked update reads in cycle 1 and writes in cycle 2. `done` is due in cycle n+1, or in cycle 3 for a masked update, and in cycle 1 for a rejected request. The bench drives inputs on falling edges and samples on falling edges. It logs every register-file access with its cycle number and compares the `done` cycle with that arithmetic. It also checks that `done` is low in the cycle that follows. `rbuf` and the status are compared in the `done` cycle, against values computed from a bench-side register function of the address.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  localparam logic [7:0] OP_PCTRL = 8'hFF;

  localparam logic [3:0] SUB_WR  = 4'd0;
  localparam logic [3:0] SUB_RD  = 4'd1;
  localparam logic [3:0] SUB_RMW = 4'd2;

  localparam logic [7:0] E_NONE = 8'd0;
  localparam logic [7:0] E_CODE = 8'd1;
  localparam logic [7:0] E_SUB  = 8'd2;
  localparam logic [7:0] E_SIZE = 8'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_MODW,
    ST_FIN
  } eng_st_t;
endpackage

// File: rtl/pwr_req_check.sv
`timescale 1ns/1ps
// Classifies an incoming request and derives the item count.
module pwr_req_check
  import pwr_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int CNT_W     = 3
) (
  input  logic [7:0]       code,
  input  logic [3:0]       sub,
  input  logic [7:0]       size,
  output logic             ok,
  output logic [7:0]       ecode,
  output logic [CNT_W-1:0] count
);
  localparam logic [7:0] MAX_B = 8'(MAX_ITEMS);

  logic [7:0] n_full;
  logic       shape_ok;

  always_comb begin
    n_full   = '0;
    shape_ok = 1'b0;
    case (sub)
      SUB_WR: begin
        n_full   = size / 8'd3;
        shape_ok = (size % 8'd3) == 8'd0;
      end
      SUB_RD: begin
        n_full   = {1'b0, size[7:1]};
        shape_ok = !size[0];
      end
      SUB_RMW: begin
        n_full   = 8'd1;
        shape_ok = size == 8'd4;
      end
      default: ;
    endcase

    ok    = 1'b0;
    ecode = E_NONE;
    if (code != OP_PCTRL)                                ecode = E_CODE;
    else if (sub > SUB_RMW)                              ecode = E_SUB;
    else if (!shape_ok || n_full == 8'd0 || n_full > MAX_B) ecode = E_SIZE;
    else                                                 ok    = 1'b1;
    count = CNT_W'(n_full);
  end

  // R4: an accepted count always lies in 1..MAX_ITEMS
  always_comb begin
    if (ok) begin
      a_r4_count_range : assert (n_full != 8'd0 && n_full <= MAX_B);
    end
  end
endmodule

// File: rtl/pwr_field_pick.sv
`timescale 1ns/1ps
// Extracts the address of item idx and its data bytes from the packed buffer.
module pwr_field_pick #(
  parameter int BUF_BYTES = 16,
  parameter int CNT_W     = 3
) (
  input  logic [8*BUF_BYTES-1:0] wbuf,
  input  logic [CNT_W-1:0]       count,
  input  logic [CNT_W-1:0]       idx,
  output logic [15:0]            addr,
  output logic [7:0]             dat,
  output logic [7:0]             dat_next
);
  localparam int IDX_W = $clog2(BUF_BYTES);

  logic [7:0] bytes [BUF_BYTES];

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_lane
    assign bytes[g] = wbuf[8*g +: 8];
  end

  logic [IDX_W-1:0] a_lo, a_hi, d_pos, d_nxt;

  assign a_lo  = IDX_W'({idx, 1'b0});
  assign a_hi  = IDX_W'(a_lo + 1'b1);
  assign d_pos = IDX_W'(IDX_W'({count, 1'b0}) + IDX_W'(idx));
  assign d_nxt = IDX_W'(d_pos + 1'b1);

  assign addr     = {bytes[a_hi], bytes[a_lo]};
  assign dat      = bytes[d_pos];
  assign dat_next = bytes[d_nxt];
endmodule

// File: rtl/pwr_reg_engine.sv
`timescale 1ns/1ps
module pwr_reg_engine
  import pwr_pkg::*;
#(
  parameter int MAX_ITEMS = 5,
  parameter int BUF_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [7:0]             cmd_code,
  input  logic [3:0]             cmd_sub,
  input  logic [7:0]             cmd_size,
  input  logic [8*BUF_BYTES-1:0] cmd_wbuf,
  output logic                   rf_en,
  output logic                   rf_we,
  output logic [15:0]            rf_addr,
  output logic [7:0]             rf_wdata,
  input  logic [7:0]             rf_rdata,
  output logic                   done,
  output logic                   err,
  output logic [7:0]             err_code,
  output logic [8*BUF_BYTES-1:0] rbuf
);
  localparam int CNT_W = $clog2(MAX_ITEMS + 1);
  localparam int BUF_W = 8 * BUF_BYTES;

  eng_st_t          st;
  logic [3:0]       sub_q;
  logic [CNT_W-1:0] cnt_q, idx_q;
  logic [BUF_W-1:0] wbuf_q, rbuf_q;
  logic             err_q;
  logic [7:0]       ec_q, old_q;

  logic             chk_ok;
  logic [7:0]       chk_ec;
  logic [CNT_W-1:0] chk_cnt;
  logic [15:0]      pk_addr;
  logic [7:0]       pk_dat, pk_next;

  pwr_req_check #(.MAX_ITEMS(MAX_ITEMS), .CNT_W(CNT_W)) u_check (
    .code (cmd_code),
    .sub  (cmd_sub),
    .size (cmd_size),
    .ok   (chk_ok),
    .ecode(chk_ec),
    .count(chk_cnt)
  );

  pwr_field_pick #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_pick (
    .wbuf    (wbuf_q),
    .count   (cnt_q),
    .idx     (idx_q),
    .addr    (pk_addr),
    .dat     (pk_dat),
    .dat_next(pk_next)
  );

  logic accept, last_item;
  assign accept    = cmd_valid && (st == ST_IDLE);
  assign last_item = idx_q == CNT_W'(cnt_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sub_q  <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      wbuf_q <= '0;
      rbuf_q <= '0;
      err_q  <= 1'b0;
      ec_q   <= E_NONE;
      old_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          sub_q  <= cmd_sub;
          cnt_q  <= chk_cnt;
          idx_q  <= '0;
          wbuf_q <= cmd_wbuf;
          rbuf_q <= '0;
          err_q  <= !chk_ok;
          ec_q   <= chk_ec;
          st     <= chk_ok ? ST_ACC : ST_FIN;
        end
        ST_ACC: begin
          if (sub_q == SUB_RMW) begin
            old_q <= rf_rdata;
            st    <= ST_MODW;
          end else begin
            if (sub_q == SUB_RD) rbuf_q[8*idx_q +: 8] <= rf_rdata;
            if (last_item) st <= ST_FIN;
            else           idx_q <= idx_q + 1'b1;
          end
        end
        ST_MODW: st <= ST_FIN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = st == ST_IDLE;
  assign rf_en     = (st == ST_ACC) || (st == ST_MODW);
  assign rf_we     = ((st == ST_ACC) && (sub_q == SUB_WR)) || (st == ST_MODW);
  assign rf_addr   = pk_addr;
  assign rf_wdata  = (st == ST_MODW) ? ((old_q & ~pk_next) | (pk_dat & pk_next)) : pk_dat;
  assign done      = st == ST_FIN;
  assign err       = err_q;
  assign err_code  = ec_q;
  assign rbuf      = rbuf_q;

  // R1: ready drops right after an accepted request
  a_r1_ready_drops : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
  // R1: no register access while idle
  a_r1_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rf_en);
  // R9: done lasts one cycle
  a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: success reports code zero, failure a nonzero code
  a_r9_code_match : assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != E_NONE)));
  // R4: a rejected request finishes one cycle after acceptance
  a_r4_reject_fast : assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> $past(cmd_valid && cmd_ready));
  // R8: the masked write follows a read of the same address
  a_r8_read_first : assert property (@(posedge clk) disable iff (!rst_n)
    rf_en && rf_we && sub_q == SUB_RMW |-> $past(rf_en && !rf_we) && $stable(rf_addr));
endmodule

// File: tb/test_pwr_reg_engine.sv
`timescale 1ns/1ps
module test_pwr_reg_engine;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [7:0]   cmd_code = '0;
  logic [3:0]   cmd_sub = '0;
  logic [7:0]   cmd_size = '0;
  logic [127:0] cmd_wbuf = '0;
  logic         rf_en, rf_we, done, err;
  logic [15:0]  rf_addr;
  logic [7:0]   rf_wdata, rf_rdata, err_code;
  logic [127:0] rbuf;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] regval(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign rf_rdata = regval(rf_addr);

  pwr_reg_engine i_pwr_reg_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_sub(cmd_sub), .cmd_size(cmd_size), .cmd_wbuf(cmd_wbuf),
    .rf_en(rf_en), .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .done(done), .err(err), .err_code(err_code), .rbuf(rbuf)
  );

  // access log, sampled on falling edges
  logic [15:0] lg_addr [16];
  logic        lg_we   [16];
  logic [7:0]  lg_wd   [16];
  int          lg_cyc  [16];
  int          lg_n = 0;
  int          cyc  = 0;

  always @(negedge clk) begin
    if (rf_en && lg_n < 16) begin
      lg_addr[lg_n] <= rf_addr;
      lg_we[lg_n]   <= rf_we;
      lg_wd[lg_n]   <= rf_wdata;
      lg_cyc[lg_n]  <= cyc;
      lg_n          <= lg_n + 1;
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int done_cyc;

  // issue one request, return when done is seen; done_cyc is its cycle number
  task automatic issue(logic [7:0] code, logic [3:0] sub, logic [7:0] size, logic [127:0] wb);
    @(negedge clk);
    chk("R1 ready idle", cmd_ready, 1);
    cmd_code = code; cmd_sub = sub; cmd_size = size; cmd_wbuf = wb;
    cmd_valid = 1'b1;
    lg_n = 0;
    cyc = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      if (cmd_ready) chk("R1 ready busy", cmd_ready, 0);
      @(negedge clk);
      cyc++;
    end
    done_cyc = cyc;
    @(negedge clk);
    chk("R9 done pulse", done, 0);
    chk("R1 ready back", cmd_ready, 1);
  endtask

  function automatic logic [15:0] mk_addr(int seed, int i);
    return 16'(seed * 16'h1357 + i * 16'h0F01 + 3);
  endfunction

  function automatic logic [7:0] mk_dat(int seed, int i);
    return 8'(seed * 37 + i * 11 + 1);
  endfunction

  task automatic run_read(int n, int seed);
    logic [127:0] wb = '0;
    logic [127:0] exp_rb = '0;
    for (int i = 0; i < n; i++) begin
      wb[16*i +: 16] = mk_addr(seed, i);
      exp_rb[8*i +: 8] = regval(mk_addr(seed, i));
    end
    issue(8'hFF, 4'd1, 8'(2*n), wb);
    chk("R9 read done cycle", done_cyc, n + 1);
    chk("R5 read count", lg_n, n);
    for (int i = 0; i < n && i < lg_n; i++) begin
      chk("R5 read addr", lg_addr[i], mk_addr(seed, i));
      chk("R5 read cycle", lg_cyc[i], i + 1);
      chk("R6 read is read", lg_we[i], 0);
    end
    chk("R6 rbuf", rbuf, exp_rb);
    chk("R9 read ok", {err, err_code}, 0);
  endtask

  task automatic run_write(int n, int seed);
    logic [127:0] wb = '0;
    for (int i = 0; i < n; i++) begin
      wb[16*i +: 16] = mk_addr(seed, i);
      wb[8*(2*n+i) +: 8] = mk_dat(seed, i);
    end
    issue(8'hFF, 4'd0, 8'(3*n), wb);
    chk("R9 write done cycle", done_cyc, n + 1);
    chk("R7 write count", lg_n, n);
    for (int i = 0; i < n && i < lg_n; i++) begin
      chk("R5 write addr", lg_addr[i], mk_addr(seed, i));
      chk("R7 write we", lg_we[i], 1);
      chk("R7 write data", lg_wd[i], mk_dat(seed, i));
    end
    chk("R10 write rbuf zero", rbuf, 0);
    chk("R9 write ok", {err, err_code}, 0);
  endtask

  task automatic run_rmw(logic [15:0] a, logic [7:0] v, logic [7:0] m);
    logic [127:0] wb = '0;
    logic [7:0] exp_w;
    wb[15:0] = a; wb[23:16] = v; wb[31:24] = m;
    exp_w = (regval(a) & ~m) | (v & m);
    issue(8'hFF, 4'd2, 8'd4, wb);
    chk("R9 rmw done cycle", done_cyc, 3);
    chk("R8 rmw count", lg_n, 2);
    if (lg_n == 2) begin
      chk("R8 rmw read", {lg_we[0], lg_addr[0]}, {1'b0, a});
      chk("R8 rmw write", {lg_we[1], lg_addr[1], lg_wd[1]}, {1'b1, a, exp_w});
      chk("R8 rmw cycles", {lg_cyc[0], lg_cyc[1]}, {32'd1, 32'd2});
    end
    chk("R10 rmw rbuf zero", rbuf, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", cmd_ready, 1);
    chk("R9 reset done", {done, err, err_code}, 0);
    chk("R10 reset rbuf", rbuf, 0);
    chk("R1 reset no access", rf_en, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 3; s++)
      for (int n = 1; n <= 5; n++) begin
        run_read(n, s * 7 + n);
        run_write(n, s * 5 + n);
      end

    run_rmw(16'h1234, 8'hFF, 8'h0F);
    run_rmw(16'hABCD, 8'h00, 8'hFF);
    run_rmw(16'h00F0, 8'h5A, 8'h00);
    run_rmw(16'hFFFF, 8'hC3, 8'hA5);

    // read after a write: rbuf replaced on accept (R10)
    run_read(2, 9);
    run_write(1, 4);

    // sweep sub-id and size; R3 and R4 classification
    for (int sb = 0; sb < 4; sb++)
      for (int sz = 0; sz < 18; sz++) begin
        logic ok;
        logic [7:0] ec;
        int n;
        ok = 1'b0; n = 0;
        if (sb == 0)      begin n = sz / 3; ok = (sz % 3 == 0) && n >= 1 && n <= 5; end
        else if (sb == 1) begin n = sz / 2; ok = (sz % 2 == 0) && n >= 1 && n <= 5; end
        else if (sb == 2) begin n = 1; ok = sz == 4; end
        ec = (sb == 3) ? 8'd2 : (ok ? 8'd0 : 8'd3);
        issue(8'hFF, 4'(sb), 8'(sz), {8{16'h0102 + 16'(sz)}});
        chk(sb == 3 ? "R3 sub code" : "R4 size code", {err, err_code}, {!ok, ec});
        if (!ok) begin
          chk("R4 reject no access", lg_n, 0);
          chk("R4 reject done cycle", done_cyc, 1);
          chk("R10 reject rbuf zero", rbuf, 0);
        end else begin
          chk("R9 sweep done cycle", done_cyc, (sb == 2) ? 3 : n + 1);
        end
      end

    // bad command codes, otherwise valid read: R2
    for (int c = 0; c < 255; c += 17) begin
      issue(8'(c), 4'd1, 8'd2, 128'h0055);
      chk("R2 code error", {err, err_code}, {1'b1, 8'd1});
      chk("R2 no access", lg_n, 0);
      chk("R2 done cycle", done_cyc, 1);
    end

    // status holds until the next accept (R10)
    repeat (5) @(negedge clk);
    chk("R10 status held", {err, err_code}, {1'b1, 8'd1});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule